// File: doc/BRIEF.md
# I2C Register Target for a Monitoring Chip

This block is the serial control port of a battery monitoring chip. It listens as a target on a two-wire I2C bus at 7-bit address 0x28 and holds a small file of 8-bit registers. Some registers drive the rest of the chip: the analog selector with two spare flag bits, a sleep request, a feature set and an unlock register. Others report hardware state: an identity and wake status register, and a pair of sticky over-temperature flags. The raw SCL and SDA inputs are synchronised and glitch-filtered on the system clock. SDA is driven only through an open-drain pull-low enable.

A host writes by sending the target byte, a register index and any number of data bytes. It reads either by first setting the index and then issuing a repeated START with the read target byte, or by sending only the read target byte, which continues from the retained index. The index steps by one after every data byte in either direction and returns to 0 after index 0x0A. The feature register is locked unless the unlock bit is set. The temperature flags clear on a read only when the condition behind them has gone away.

Top module: `i2c_regfile_target`

## Requirements
- R1: The target answers only to target byte 0x50 (write) and 0x51 (read). Any other target byte gets no acknowledge, meaning SDA stays released in the ninth clock.
- R2: A write is the target byte, the register index, then data bytes, each acknowledged. A data byte reaches its register output once the SCL falling edge after its eighth bit has been seen.
- R3: The index increments after every data byte written or read, and the step after index 0x0A goes to 0x00.
- R4: A random read (index write, repeated START, 0x51) returns the register at the given index. A read with only 0x51 returns the register at the retained index.
- R5: Read data leaves MSB first. After a host ACK the next register follows. After a host NACK the target stops driving SDA.
- R6: Register 0x07 (feature: bits 7,6,5,2,1,0 stored, bit 0 the wake polarity) changes only while bit 7 of register 0x08 is 1. Register 0x08 stores bits 7,4,3 and resets to 0x00.
- R7: In register 0x01, bit 5 (external hot) and bit 4 (internal hot) are set while their input is high and then hold. A read of 0x01 clears a bit only if its input is low at that read.
- R8: Register 0x00 reads bit 5 as 1. Bit 4 equals the wake pin when the polarity bit is 1 and its inverse when the polarity bit is 0. All other bits read 0.
- R9: A pulse on SCL or SDA shorter than FILT_CYC system clocks has no effect on the transfer.
- R10: A STOP at any point ends the transfer without writing a partial byte. Bytes clocked after it, with no START, are not acknowledged.
- R11: Indices 0x02, 0x05, 0x06 and 0x09 upward read 0x00 and ignore writes. Register 0x03 stores bits 7,6,3:0 and register 0x04 stores bit 7. Unstored bits read 0, and all registers reset to 0x00.
- R12: The SDA pull-low enable changes only while the filtered SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Raw bus clock level |
| sda_i | input | 1 | Raw bus data level |
| sda_oe | output | 1 | 1 pulls SDA low |
| ext_hot | input | 1 | External over-temperature condition |
| int_hot | input | 1 | Internal over-temperature condition |
| wake_pin | input | 1 | Wake pin level after its comparator |
| mux_sel_reg | output | 8 | Register 0x03 contents |
| control_reg | output | 8 | Register 0x04 contents |
| feature_reg | output | 8 | Register 0x07 contents |
| unlock_reg | output | 8 | Register 0x08 contents |

## Verification
The bench builds the block with FILT_CYC set to 4 instead of 10, with the default address 0x28 and wrap index 0x0A. It runs the bus at twelve system clocks per quarter bit. With a short filter, three-clock glitches on SCL during a low phase and on SDA during a high phase can sit inside a real data byte and still end up below the rejection threshold. The small wrap index lets one five-byte burst and one two-byte read cross the 0x0A to 0x00 boundary.

// File: rtl/i2c_rf_pkg.sv
package i2c_rf_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    // register indices whose position other logic depends on
    localparam logic [7:0] A_ID     = 8'h00;
    localparam logic [7:0] A_TEMP   = 8'h01;
    localparam logic [7:0] A_MUX    = 8'h03;
    localparam logic [7:0] A_CTRL   = 8'h04;
    localparam logic [7:0] A_FEAT   = 8'h07;
    localparam logic [7:0] A_UNLOCK = 8'h08;

    // stored-bit masks
    localparam logic [7:0] M_MUX    = 8'hCF;
    localparam logic [7:0] M_CTRL   = 8'h80;
    localparam logic [7:0] M_FEAT   = 8'hE7;
    localparam logic [7:0] M_UNLOCK = 8'h98;

    localparam int UNLOCK_BIT = 7;
    localparam int POL_BIT    = 0;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_TXACK
    } eng_st_e;

    typedef enum logic [1:0] {
        PH_DEV,
        PH_INDEX,
        PH_DATA
    } phase_e;

    typedef struct packed {
        logic [BYTE_W-1:0] mux;
        logic [BYTE_W-1:0] ctrl;
        logic [BYTE_W-1:0] feat;
        logic [BYTE_W-1:0] unlock;
    } ctrl_regs_t;

    function automatic logic [BYTE_W-1:0] ptr_step(input logic [BYTE_W-1:0] p,
                                                   input logic [BYTE_W-1:0] last);
        return (p >= last) ? '0 : p + 1'b1;
    endfunction

endpackage

// File: rtl/i2c_rf_filter.sv
module i2c_rf_filter #(
    parameter int FILT_CYC = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    localparam int CW = $clog2(FILT_CYC + 1);

    logic [1:0]    sync_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= 2'b11;
            dout   <= 1'b1;
            cnt_q  <= '0;
        end else begin
            sync_q <= {sync_q[0], din};
            if (sync_q[1] == dout) begin
                cnt_q <= '0;
            end else if (cnt_q == CW'(FILT_CYC - 1)) begin
                dout  <= sync_q[1];
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/i2c_rf_engine.sv
module i2c_rf_engine
    import i2c_rf_pkg::*;
#(
    parameter logic [6:0]        DEV_ADDR  = 7'h28,
    parameter logic [BYTE_W-1:0] LAST_ADDR = 8'h0A
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl,
    input  logic              sda,
    output logic              sda_oe,
    output logic [BYTE_W-1:0] look_addr,
    input  logic [BYTE_W-1:0] look_data,
    output logic              wr_stb,
    output logic [BYTE_W-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic              rd_stb,
    output logic [BYTE_W-1:0] rd_addr
);
    logic scl_d, sda_d;
    logic scl_rise, scl_fall, bus_start, bus_stop;

    eng_st_e           st_q;
    phase_e            ph_q;
    logic [CNT_W-1:0]  bit_q;
    logic [BYTE_W-1:0] sh_q;
    logic [BYTE_W-1:0] ptr_q;
    logic              rw_q;
    logic              mack_q;

    assign scl_rise  =  scl & ~scl_d;
    assign scl_fall  = ~scl &  scl_d;
    assign bus_start =  scl &  scl_d &  sda_d & ~sda;
    assign bus_stop  =  scl &  scl_d & ~sda_d &  sda;
    assign look_addr = ptr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_d   <= 1'b1;
            sda_d   <= 1'b1;
            st_q    <= ST_IDLE;
            ph_q    <= PH_DEV;
            bit_q   <= '0;
            sh_q    <= '0;
            ptr_q   <= '0;
            rw_q    <= 1'b0;
            mack_q  <= 1'b0;
            sda_oe  <= 1'b0;
            wr_stb  <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
            rd_stb  <= 1'b0;
            rd_addr <= '0;
        end else begin
            scl_d  <= scl;
            sda_d  <= sda;
            wr_stb <= 1'b0;
            rd_stb <= 1'b0;
            if (bus_stop) begin
                st_q   <= ST_IDLE;
                sda_oe <= 1'b0;
            end else if (bus_start) begin
                st_q   <= ST_RX;
                ph_q   <= PH_DEV;
                bit_q  <= '0;
                sda_oe <= 1'b0;
            end else begin
                unique case (st_q)
                    ST_RX: begin
                        if (scl_rise) begin
                            sh_q  <= {sh_q[BYTE_W-2:0], sda};
                            bit_q <= bit_q + 1'b1;
                        end else if (scl_fall && bit_q == CNT_W'(BYTE_W)) begin
                            bit_q <= '0;
                            unique case (ph_q)
                                PH_DEV: begin
                                    if (sh_q[BYTE_W-1:1] == DEV_ADDR) begin
                                        rw_q   <= sh_q[0];
                                        st_q   <= ST_ACK;
                                        sda_oe <= 1'b1;
                                    end else begin
                                        st_q <= ST_IDLE;
                                    end
                                end
                                PH_INDEX: begin
                                    ptr_q  <= sh_q;
                                    st_q   <= ST_ACK;
                                    sda_oe <= 1'b1;
                                end
                                default: begin
                                    wr_stb  <= 1'b1;
                                    wr_addr <= ptr_q;
                                    wr_data <= sh_q;
                                    ptr_q   <= ptr_step(ptr_q, LAST_ADDR);
                                    st_q    <= ST_ACK;
                                    sda_oe  <= 1'b1;
                                end
                            endcase
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            bit_q <= '0;
                            if (ph_q == PH_DEV && rw_q) begin
                                sh_q    <= look_data;
                                rd_stb  <= 1'b1;
                                rd_addr <= ptr_q;
                                ptr_q   <= ptr_step(ptr_q, LAST_ADDR);
                                sda_oe  <= ~look_data[BYTE_W-1];
                                st_q    <= ST_TX;
                            end else begin
                                sda_oe <= 1'b0;
                                st_q   <= ST_RX;
                                ph_q   <= (ph_q == PH_DEV) ? PH_INDEX : PH_DATA;
                            end
                        end
                    end
                    ST_TX: begin
                        if (scl_fall) begin
                            if (bit_q == CNT_W'(BYTE_W - 1)) begin
                                sda_oe <= 1'b0;
                                st_q   <= ST_TXACK;
                            end else begin
                                sh_q   <= {sh_q[BYTE_W-2:0], 1'b0};
                                sda_oe <= ~sh_q[BYTE_W-2];
                                bit_q  <= bit_q + 1'b1;
                            end
                        end
                    end
                    ST_TXACK: begin
                        if (scl_rise) begin
                            mack_q <= ~sda;
                        end else if (scl_fall) begin
                            if (mack_q) begin
                                bit_q   <= '0;
                                sh_q    <= look_data;
                                rd_stb  <= 1'b1;
                                rd_addr <= ptr_q;
                                ptr_q   <= ptr_step(ptr_q, LAST_ADDR);
                                sda_oe  <= ~look_data[BYTE_W-1];
                                st_q    <= ST_TX;
                            end else begin
                                st_q <= ST_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/i2c_rf_regs.sv
module i2c_rf_regs
    import i2c_rf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_stb,
    input  logic [BYTE_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              rd_stb,
    input  logic [BYTE_W-1:0] rd_addr,
    input  logic [BYTE_W-1:0] look_addr,
    output logic [BYTE_W-1:0] look_data,
    input  logic              ext_hot,
    input  logic              int_hot,
    input  logic              wake_pin,
    output ctrl_regs_t        regs_o
);
    ctrl_regs_t regs_q;
    logic [1:0] temp_q;
    logic [1:0] hot_now;
    logic [1:0] temp_clr;
    logic [1:0] wake_sync;
    logic       wake_stat;

    assign hot_now   = {ext_hot, int_hot};
    assign temp_clr  = (rd_stb && rd_addr == A_TEMP) ? ~hot_now : 2'b00;
    assign wake_stat = regs_q.feat[POL_BIT] ? wake_sync[1] : ~wake_sync[1];
    assign regs_o    = regs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q    <= '0;
            temp_q    <= '0;
            wake_sync <= '0;
        end else begin
            wake_sync <= {wake_sync[0], wake_pin};
            temp_q    <= hot_now | (temp_q & ~temp_clr);
            if (wr_stb) begin
                unique case (wr_addr)
                    A_MUX:    regs_q.mux    <= wr_data & M_MUX;
                    A_CTRL:   regs_q.ctrl   <= wr_data & M_CTRL;
                    A_UNLOCK: regs_q.unlock <= wr_data & M_UNLOCK;
                    A_FEAT: begin
                        if (regs_q.unlock[UNLOCK_BIT]) begin
                            regs_q.feat <= wr_data & M_FEAT;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        unique case (look_addr)
            A_ID:     look_data = {2'b00, 1'b1, wake_stat, 4'b0000};
            A_TEMP:   look_data = {2'b00, temp_q, 4'b0000};
            A_MUX:    look_data = regs_q.mux;
            A_CTRL:   look_data = regs_q.ctrl;
            A_FEAT:   look_data = regs_q.feat;
            A_UNLOCK: look_data = regs_q.unlock;
            default:  look_data = '0;
        endcase
    end
endmodule

// File: rtl/i2c_regfile_target.sv
module i2c_regfile_target
    import i2c_rf_pkg::*;
#(
    parameter logic [6:0]        DEV_ADDR  = 7'h28,
    parameter logic [BYTE_W-1:0] LAST_ADDR = 8'h0A,
    parameter int                FILT_CYC  = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic              ext_hot,
    input  logic              int_hot,
    input  logic              wake_pin,
    output logic [BYTE_W-1:0] mux_sel_reg,
    output logic [BYTE_W-1:0] control_reg,
    output logic [BYTE_W-1:0] feature_reg,
    output logic [BYTE_W-1:0] unlock_reg
);
    logic [1:0]        raw_lines;
    logic [1:0]        filt_lines;
    logic              scl_f, sda_f;
    logic [BYTE_W-1:0] look_addr, look_data;
    logic              wr_stb, rd_stb;
    logic [BYTE_W-1:0] wr_addr, wr_data, rd_addr;
    ctrl_regs_t        regs;

    assign raw_lines = {scl_i, sda_i};

    for (genvar g = 0; g < 2; g++) begin : g_filt
        i2c_rf_filter #(.FILT_CYC(FILT_CYC)) u_filt (
            .clk  (clk),
            .rst  (rst),
            .din  (raw_lines[g]),
            .dout (filt_lines[g])
        );
    end

    assign scl_f = filt_lines[1];
    assign sda_f = filt_lines[0];

    i2c_rf_engine #(.DEV_ADDR(DEV_ADDR), .LAST_ADDR(LAST_ADDR)) u_engine (
        .clk       (clk),
        .rst       (rst),
        .scl       (scl_f),
        .sda       (sda_f),
        .sda_oe    (sda_oe),
        .look_addr (look_addr),
        .look_data (look_data),
        .wr_stb    (wr_stb),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_stb    (rd_stb),
        .rd_addr   (rd_addr)
    );

    i2c_rf_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_stb    (wr_stb),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_stb    (rd_stb),
        .rd_addr   (rd_addr),
        .look_addr (look_addr),
        .look_data (look_data),
        .ext_hot   (ext_hot),
        .int_hot   (int_hot),
        .wake_pin  (wake_pin),
        .regs_o    (regs)
    );

    assign mux_sel_reg = regs.mux;
    assign control_reg = regs.ctrl;
    assign feature_reg = regs.feat;
    assign unlock_reg  = regs.unlock;
endmodule

// File: rtl/i2c_rf_chk.sv
module i2c_rf_chk (
    input logic       clk,
    input logic       rst,
    input logic       scl_f,
    input logic       sda_oe,
    input logic       wr_stb,
    input logic [7:0] wr_addr,
    input logic       rd_stb,
    input logic [7:0] rd_addr,
    input logic [7:0] feat,
    input logic [7:0] unlock,
    input logic       ext_hot,
    input logic       int_hot,
    input logic [1:0] temp_q
);
    // R6: a write to the feature register while locked leaves it unchanged
    a_r6_feat_locked: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && wr_addr == 8'h07 && !unlock[7]) |=> $stable(feat));

    // R6: the unlock register comes out of reset cleared
    a_r6_unlock_reset: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (unlock == 8'h00));

    // R7: a present condition sets its flag
    a_r7_ext_sets: assert property (@(posedge clk) disable iff (rst)
        ext_hot |=> temp_q[1]);

    a_r7_int_sets: assert property (@(posedge clk) disable iff (rst)
        int_hot |=> temp_q[0]);

    // R7: a set flag holds unless the status register is read
    a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
        (temp_q[1] && !(rd_stb && rd_addr == 8'h01)) |=> temp_q[1]);

    // R12: the pull-low enable does not move while SCL stays high
    a_r12_oe_steady: assert property (@(posedge clk) disable iff (rst)
        (scl_f && $past(scl_f)) |-> $stable(sda_oe));
endmodule

bind i2c_regfile_target i2c_rf_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .scl_f   (scl_f),
    .sda_oe  (sda_oe),
    .wr_stb  (wr_stb),
    .wr_addr (wr_addr),
    .rd_stb  (rd_stb),
    .rd_addr (rd_addr),
    .feat    (feature_reg),
    .unlock  (unlock_reg),
    .ext_hot (ext_hot),
    .int_hot (int_hot),
    .temp_q  (u_regs.temp_q)
);

// File: tb/test_i2c_regfile_target.sv
`timescale 1ns/1ps
module test_i2c_regfile_target;
    localparam int Q = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic ext_hot = 1'b0;
    logic int_hot = 1'b0;
    logic wake_pin = 1'b1;
    logic sda_oe;
    logic sda_line;
    logic [7:0] mux_sel_reg, control_reg, feature_reg, unlock_reg;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    i2c_regfile_target #(.FILT_CYC(4)) i_i2c_regfile_target (
        .clk         (clk),
        .rst         (rst),
        .scl_i       (scl_m),
        .sda_i       (sda_line),
        .sda_oe      (sda_oe),
        .ext_hot     (ext_hot),
        .int_hot     (int_hot),
        .wake_pin    (wake_pin),
        .mux_sel_reg (mux_sel_reg),
        .control_reg (control_reg),
        .feature_reg (feature_reg),
        .unlock_reg  (unlock_reg)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clocks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic qwait();
        clocks(Q);
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; qwait();
        scl_m = 1'b1; qwait();
        sda_m = 1'b0; qwait();
        scl_m = 1'b0;
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; qwait();
        scl_m = 1'b1; qwait();
        sda_m = 1'b1; qwait();
    endtask

    task automatic bit_out_g(input logic b, input bit g_scl, input bit g_sda);
        if (g_scl) begin
            clocks(4);
            scl_m = 1'b1; clocks(3); scl_m = 1'b0;
            clocks(Q - 7);
        end else begin
            qwait();
        end
        sda_m = b; qwait();
        scl_m = 1'b1; qwait();
        if (g_sda) begin
            sda_m = 1'b0; clocks(3); sda_m = b;
            clocks(Q - 3);
        end else begin
            qwait();
        end
        scl_m = 1'b0;
    endtask

    task automatic bit_out(input logic b);
        bit_out_g(b, 1'b0, 1'b0);
    endtask

    task automatic bit_in(output logic b);
        qwait(); sda_m = 1'b1; qwait();
        scl_m = 1'b1; qwait();
        b = sda_line; qwait();
        scl_m = 1'b0;
    endtask

    task automatic wbyte(input logic [7:0] v, output logic nack);
        for (int i = 7; i >= 0; i--) bit_out(v[i]);
        bit_in(nack);
    endtask

    task automatic rbyte(input logic give_nack, output logic [7:0] v);
        for (int i = 7; i >= 0; i--) bit_in(v[i]);
        bit_out(give_nack);
    endtask

    // first byte in d[63:56]
    task automatic write_burst(input logic [7:0] a, input int n, input logic [63:0] d);
        logic nk;
        logic any_nk;
        i2c_start();
        wbyte(8'h50, nk); any_nk = nk;
        wbyte(a, nk); any_nk |= nk;
        for (int k = 0; k < n; k++) begin
            wbyte(d[63 - 8*k -: 8], nk);
            any_nk |= nk;
        end
        i2c_stop();
        clocks(4);
        check("R2 every write byte acknowledged", {31'd0, any_nk}, 32'd0);
    endtask

    task automatic write_reg(input logic [7:0] a, input logic [7:0] v);
        write_burst(a, 1, {v, 56'd0});
    endtask

    task automatic read_reg(input logic [7:0] a, output logic [7:0] v);
        logic nk;
        i2c_start();
        wbyte(8'h50, nk);
        wbyte(a, nk);
        i2c_start();
        wbyte(8'h51, nk);
        rbyte(1'b1, v);
        i2c_stop();
    endtask

    task automatic t_reset();
        check("R11 reset register outputs", {mux_sel_reg, control_reg, feature_reg, unlock_reg}, 32'd0);
        check("R6 unlock register resets to 0", {24'd0, unlock_reg}, 32'd0);
        check("R12 SDA released after reset", {31'd0, sda_oe}, 32'd0);
    endtask

    task automatic t_address();
        logic nk;
        i2c_start(); wbyte(8'h52, nk); i2c_stop();
        check("R1 foreign target byte not acknowledged", {31'd0, nk}, 32'd1);
        i2c_start(); wbyte(8'h50, nk); i2c_stop();
        check("R1 own write target byte acknowledged", {31'd0, nk}, 32'd0);
        i2c_start(); wbyte(8'h51, nk);
        begin
            logic [7:0] v;
            rbyte(1'b1, v);
        end
        i2c_stop();
        check("R1 own read target byte acknowledged", {31'd0, nk}, 32'd0);
    endtask

    task automatic t_write();
        logic [7:0] v;
        write_reg(8'h03, 8'hFF);
        check("R2 single write lands (R11 mask 0xCF)", {24'd0, mux_sel_reg}, 32'hCF);
        read_reg(8'h03, v);
        check("R4 random read of register 0x03", {24'd0, v}, 32'hCF);
    endtask

    task automatic t_burst();
        write_burst(8'h03, 2, {8'h35, 8'hFF, 48'd0});
        check("R3 burst first byte to 0x03", {24'd0, mux_sel_reg}, 32'h05);
        check("R3 burst second byte to 0x04", {24'd0, control_reg}, 32'h80);
    endtask

    task automatic t_wrap();
        logic nk;
        logic [7:0] v0, v1;
        write_burst(8'h0A, 5, {8'h77, 8'h77, 8'h77, 8'h77, 8'h42, 24'd0});
        check("R3 write burst wraps 0x0A to 0x00 and reaches 0x03", {24'd0, mux_sel_reg}, 32'h42);
        i2c_start();
        wbyte(8'h50, nk); wbyte(8'h0A, nk);
        i2c_start();
        wbyte(8'h51, nk);
        rbyte(1'b0, v0);
        rbyte(1'b1, v1);
        i2c_stop();
        check("R11 reserved index 0x0A reads 0", {24'd0, v0}, 32'h00);
        check("R3 read wraps to index 0x00 (R8 id 0x20)", {24'd0, v1}, 32'h20);
    endtask

    task automatic t_reads();
        logic nk;
        logic [7:0] v0, v1;
        i2c_start();
        wbyte(8'h50, nk); wbyte(8'h03, nk);
        i2c_start();
        wbyte(8'h51, nk);
        rbyte(1'b0, v0);
        rbyte(1'b1, v1);
        qwait();
        check("R5 SDA released after host NACK", {31'd0, sda_oe}, 32'd0);
        i2c_stop();
        check("R5 first read byte", {24'd0, v0}, 32'h42);
        check("R5 ACK continues with next register", {24'd0, v1}, 32'h80);
        read_reg(8'h03, v0);
        i2c_start();
        wbyte(8'h51, nk);
        rbyte(1'b1, v1);
        i2c_stop();
        check("R4 current-address read uses retained index", {24'd0, v1}, 32'h80);
    endtask

    task automatic t_reserved();
        logic [7:0] v;
        write_reg(8'h04, 8'hFF);
        check("R11 register 0x04 keeps bit 7 only", {24'd0, control_reg}, 32'h80);
        write_reg(8'h05, 8'hFF);
        read_reg(8'h05, v);
        check("R11 reserved index 0x05 ignores write", {24'd0, v}, 32'h00);
        read_reg(8'h09, v);
        check("R11 reserved index 0x09 reads 0", {24'd0, v}, 32'h00);
    endtask

    task automatic t_protect();
        write_reg(8'h07, 8'hFF);
        check("R6 locked feature write ignored", {24'd0, feature_reg}, 32'h00);
        write_reg(8'h08, 8'hFF);
        check("R6 unlock register stores 0x98", {24'd0, unlock_reg}, 32'h98);
        write_reg(8'h07, 8'hFF);
        check("R6 unlocked feature write lands", {24'd0, feature_reg}, 32'hE7);
        write_reg(8'h08, 8'h00);
        write_reg(8'h07, 8'h00);
        check("R6 relocked feature keeps value", {24'd0, feature_reg}, 32'hE7);
    endtask

    task automatic t_wake();
        logic [7:0] v;
        wake_pin = 1'b1; clocks(8);
        read_reg(8'h00, v);
        check("R8 polarity 1 pin high", {24'd0, v}, 32'h30);
        wake_pin = 1'b0; clocks(8);
        read_reg(8'h00, v);
        check("R8 polarity 1 pin low", {24'd0, v}, 32'h20);
        write_reg(8'h08, 8'h80);
        write_reg(8'h07, 8'h00);
        write_reg(8'h08, 8'h00);
        read_reg(8'h00, v);
        check("R8 polarity 0 pin low", {24'd0, v}, 32'h30);
        wake_pin = 1'b1; clocks(8);
    endtask

    task automatic t_status();
        logic [7:0] v;
        ext_hot = 1'b1; clocks(5); ext_hot = 1'b0; clocks(5);
        read_reg(8'h01, v);
        check("R7 external flag latched", {24'd0, v}, 32'h20);
        read_reg(8'h01, v);
        check("R7 external flag cleared by read", {24'd0, v}, 32'h00);
        int_hot = 1'b1; clocks(5);
        read_reg(8'h01, v);
        check("R7 internal flag set", {24'd0, v}, 32'h10);
        read_reg(8'h01, v);
        check("R7 read keeps flag while condition present", {24'd0, v}, 32'h10);
        int_hot = 1'b0; clocks(5);
        read_reg(8'h01, v);
        check("R7 flag held after condition ends", {24'd0, v}, 32'h10);
        read_reg(8'h01, v);
        check("R7 flag cleared by later read", {24'd0, v}, 32'h00);
    endtask

    task automatic t_stop();
        logic nk;
        i2c_start();
        wbyte(8'h50, nk); wbyte(8'h03, nk);
        bit_out(1'b1); bit_out(1'b0); bit_out(1'b1); bit_out(1'b0);
        i2c_stop();
        clocks(4);
        check("R10 partial byte before STOP not written", {24'd0, mux_sel_reg}, 32'h42);
        wbyte(8'h50, nk);
        check("R10 byte without START not acknowledged", {31'd0, nk}, 32'd1);
        i2c_stop();
    endtask

    task automatic t_glitch();
        logic nk;
        logic [7:0] d;
        d = 8'h8A;
        i2c_start();
        wbyte(8'h50, nk); wbyte(8'h03, nk);
        for (int i = 7; i >= 0; i--) bit_out_g(d[i], i == 5, i == 3);
        bit_in(nk);
        i2c_stop();
        clocks(4);
        check("R9 short pulses on SCL and SDA ignored", {24'd0, mux_sel_reg}, 32'h8A);
        check("R9 glitched byte still acknowledged", {31'd0, nk}, 32'd0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        clocks(10);
        rst = 1'b0;
        clocks(20);
        t_reset();
        t_address();
        t_write();
        t_burst();
        t_wrap();
        t_reads();
        t_reserved();
        t_protect();
        t_wake();
        t_status();
        t_stop();
        t_glitch();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule